// File: doc/BRIEF.md
# Card-Interface Bus Cycle Timing Generator

This block times each access to a slow external memory area of the card type. A single request carries an address, a direction, a size (byte or word), a flag that marks it as a DMA beat, a register-space flag, an area select and a last-beat flag. The block then runs a fixed phase sequence. First come programmable idle cycles before the access. Setup follows, with address and enables stable and no strobe. Next is the strobe, whose length is a base wait count plus a coarse speed adder. Hold follows, with enables still valid after the strobe. A single done cycle closes the access.

All timing and mode fields are static configuration inputs. In the ATA-complement mode the two card enables are encoded from the access size and its source. DMA beats in that mode assert neither enable. A DMA acknowledge can be held across a whole burst once an arm pulse has been given. The arm is used up when the burst's last beat completes.

Top module: `card_cycle_gen`

## Requirements
- R1: After reset every output is low and `req_ready_o` is high. A request is taken at a rising clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high only while no access is in progress.
- R2: The strobe (`rd_o` or `wr_o`) stays high for exactly `cfg_base_wait_i` + A + 1 consecutive cycles. A is 0, 15, 30 or 50 for `cfg_speed_i` = 0, 1, 2 or 3.
- R3: Between acceptance and the first strobe cycle there are exactly `cfg_setup_i` cycles with no strobe. Through setup, strobe and hold, `bus_addr_o` equals the accepted address and `reg_o` equals the accepted `req_reg_i`.
- R4: After the last strobe cycle there are exactly `cfg_hold_i` cycles with no strobe. They are followed by one cycle where `done_o`=1 and `ce1_o`, `ce2_o`, `rd_o` and `wr_o` are all 0.
- R5: A read (`req_write_i`=0) drives only `rd_o` and a write drives only `wr_o`. The two are never high together.
- R6: With `cfg_ata_i`=0, `ce1_o` is 1 for every access and `ce2_o` is 1 only for a word access (`req_word_i`=1). Both apply through setup, strobe and hold.
- R7: With `cfg_ata_i`=1, the enables depend on the access. A CPU byte access gives `ce1_o`=0 and `ce2_o`=1. A CPU word access gives `ce1_o`=1 and `ce2_o`=0. A DMA access (`req_dma_i`=1) gives both 0.
- R8: Without an armed burst, `dack_o` is high exactly during the setup, strobe and hold cycles of a DMA access. It is low in idle and done cycles.
- R9: A `burst_arm_i` pulse arms the burst acknowledge. The next DMA beat taken while armed starts a burst. `dack_o` then stays high from that beat's first active cycle through the done cycle of the DMA beat taken with `req_last_i`=1. That beat also disarms the mode, so later DMA beats pulse `dack_o` per R8. `req_last_i` has no effect while not armed.
- R10: Suppose an access's done cycle is cycle d. The next request is not accepted before cycle d+1+N. N is `cfg_idle1_i` when the pending request has `req_area_i`=1, and `cfg_idle0_i` otherwise.
- R11: With setup and hold both 0, the strobe rises in the cycle right after acceptance. The done cycle directly follows the last strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_addr_i | input | AW | Access address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_word_i | input | 1 | 1 = word access, 0 = byte access |
| req_dma_i | input | 1 | Access is a DMA beat |
| req_reg_i | input | 1 | Register-space access |
| req_area_i | input | 1 | Target area (0 or 1), selects idle setting |
| req_last_i | input | 1 | Last beat of a DMA burst |
| burst_arm_i | input | 1 | Pulse arming burst acknowledge |
| cfg_ata_i | input | 1 | ATA-complement enable encoding |
| cfg_base_wait_i | input | BW | Base wait count |
| cfg_speed_i | input | 2 | Coarse wait adder select |
| cfg_setup_i | input | CW | Setup cycles |
| cfg_hold_i | input | CW | Hold cycles |
| cfg_idle0_i | input | IW | Idle cycles before an area-0 access |
| cfg_idle1_i | input | IW | Idle cycles before an area-1 access |
| bus_addr_o | output | AW | Address to the card |
| ce1_o | output | 1 | Card enable 1 |
| ce2_o | output | 1 | Card enable 2 |
| reg_o | output | 1 | Register-space select |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| dack_o | output | 1 | DMA acknowledge |
| done_o | output | 1 | Access completion cycle |

## Verification
The hardest case to reach is the burst acknowledge. It needs an arm pulse that lands on or before the first DMA beat is taken, and back-to-back DMA beats with idle gaps. The acknowledge must stay high through those gaps and then drop after the last beat, and the next unarmed beat must revert to per-beat pulses. The stimulus reaches this with a directed sequence. The arm pulse is driven in the same cycle as the first beat's request. Three DMA beats follow, the last one flagged, and then two unarmed DMA beats. A bench model of the armed and running state predicts `dack_o` in every idle, active and done cycle. Random back-to-back traffic with random timing fields covers the idle-gap selection by the pending request's area.

// File: rtl/card_cyc_pkg.sv
package card_cyc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_DONE   = 3'd4
  } phase_e;

  typedef struct packed {
    logic write;
    logic word;
    logic dma;
    logic regsel;
    logic last;
  } req_attr_t;
endpackage

// File: rtl/card_wait_sum.sv
module card_wait_sum #(
  parameter int BW    = 4,
  parameter int TW    = 7,
  parameter int ADD_1 = 15,
  parameter int ADD_2 = 30,
  parameter int ADD_3 = 50
) (
  input  logic [BW-1:0] base_i,
  input  logic [1:0]    speed_i,
  output logic [TW-1:0] total_o
);
  logic [TW-1:0] adder;

  always_comb begin
    unique case (speed_i)
      2'd0:    adder = '0;
      2'd1:    adder = TW'(ADD_1);
      2'd2:    adder = TW'(ADD_2);
      default: adder = TW'(ADD_3);
    endcase
  end

  assign total_o = TW'(base_i) + adder;
endmodule

// File: rtl/card_ce_enc.sv
module card_ce_enc (
  input  logic active_i,
  input  logic ata_i,
  input  logic word_i,
  input  logic dma_i,
  output logic ce1_o,
  output logic ce2_o
);
  always_comb begin
    ce1_o = 1'b0;
    ce2_o = 1'b0;
    if (active_i) begin
      if (ata_i) begin
        // size and source select the enable; DMA uses neither
        ce1_o = !dma_i && word_i;
        ce2_o = !dma_i && !word_i;
      end else begin
        ce1_o = 1'b1;
        ce2_o = word_i;
      end
    end
  end
endmodule

// File: rtl/card_burst_ack.sv
module card_burst_ack (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic start_i,
  input  logic end_i,
  output logic run_o
);
  logic armed_q, run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
    end else if (end_i && run_q) begin
      run_q   <= 1'b0;
      armed_q <= arm_i;  // a fresh arm pulse wins over the self-clear
    end else begin
      if (arm_i) armed_q <= 1'b1;
      if (start_i && (armed_q || arm_i)) run_q <= 1'b1;
    end
  end

  assign run_o = run_q;

  // R9: a burst starts only from an armed state
  a_r9_run_from_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_q) |-> $past(armed_q || arm_i));

  // R9: the arm stays set for the whole burst
  a_r9_armed_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> armed_q);
endmodule

// File: rtl/card_cycle_gen.sv
module card_cycle_gen
  import card_cyc_pkg::*;
#(
  parameter int AW    = 26,
  parameter int BW    = 4,
  parameter int CW    = 4,
  parameter int IW    = 3,
  parameter int ADD_1 = 15,
  parameter int ADD_2 = 30,
  parameter int ADD_3 = 50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_write_i,
  input  logic          req_word_i,
  input  logic          req_dma_i,
  input  logic          req_reg_i,
  input  logic          req_area_i,
  input  logic          req_last_i,
  input  logic          burst_arm_i,
  input  logic          cfg_ata_i,
  input  logic [BW-1:0] cfg_base_wait_i,
  input  logic [1:0]    cfg_speed_i,
  input  logic [CW-1:0] cfg_setup_i,
  input  logic [CW-1:0] cfg_hold_i,
  input  logic [IW-1:0] cfg_idle0_i,
  input  logic [IW-1:0] cfg_idle1_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          ce1_o,
  output logic          ce2_o,
  output logic          reg_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          dack_o,
  output logic          done_o
);
  localparam int MAXW  = (1 << BW) - 1 + ADD_3;
  localparam int TW    = $clog2(MAXW + 1);
  localparam int CNT_W = (TW > CW) ? TW : CW;

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [TW-1:0]     wait_q, total_wait;
  logic [CW-1:0]     hold_q;
  logic [IW-1:0]     gap_q, idle_sel;
  logic [AW-1:0]     addr_q;
  req_attr_t         attr_q;
  logic              accept, active, burst_run;

  card_wait_sum #(
    .BW(BW), .TW(TW), .ADD_1(ADD_1), .ADD_2(ADD_2), .ADD_3(ADD_3)
  ) u_wait (
    .base_i (cfg_base_wait_i),
    .speed_i(cfg_speed_i),
    .total_o(total_wait)
  );

  // idle requirement follows the area of the pending request
  assign idle_sel    = req_area_i ? cfg_idle1_i : cfg_idle0_i;
  assign req_ready_o = (ph_q == PH_IDLE) && (gap_q >= idle_sel);
  assign accept      = req_valid_i && req_ready_o;
  assign active      = (ph_q == PH_SETUP) || (ph_q == PH_STROBE) || (ph_q == PH_HOLD);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (accept) begin
          if (cfg_setup_i != '0) begin
            ph_d  = PH_SETUP;
            cnt_d = CNT_W'(cfg_setup_i - 1'b1);
          end else begin
            ph_d  = PH_STROBE;
            cnt_d = CNT_W'(total_wait);
          end
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          ph_d  = PH_STROBE;
          cnt_d = CNT_W'(wait_q);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (hold_q != '0) begin
          ph_d  = PH_HOLD;
          cnt_d = CNT_W'(hold_q - 1'b1);
        end else begin
          ph_d  = PH_DONE;
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) ph_d = PH_DONE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      wait_q <= '0;
      hold_q <= '0;
      gap_q  <= '1;
      addr_q <= '0;
      attr_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (accept) begin
        wait_q <= total_wait;
        hold_q <= cfg_hold_i;
        addr_q <= req_addr_i;
        attr_q <= '{write: req_write_i, word: req_word_i, dma: req_dma_i,
                    regsel: req_reg_i, last: req_last_i};
      end
      if (ph_q == PH_DONE)                      gap_q <= '0;
      else if (ph_q == PH_IDLE && gap_q != '1)  gap_q <= gap_q + 1'b1;
    end
  end

  card_ce_enc u_ce (
    .active_i(active),
    .ata_i   (cfg_ata_i),
    .word_i  (attr_q.word),
    .dma_i   (attr_q.dma),
    .ce1_o   (ce1_o),
    .ce2_o   (ce2_o)
  );

  card_burst_ack u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (burst_arm_i),
    .start_i(accept && req_dma_i),
    .end_i  ((ph_q == PH_DONE) && attr_q.dma && attr_q.last),
    .run_o  (burst_run)
  );

  assign bus_addr_o = addr_q;
  assign reg_o      = active && attr_q.regsel;
  assign rd_o       = (ph_q == PH_STROBE) && !attr_q.write;
  assign wr_o       = (ph_q == PH_STROBE) && attr_q.write;
  assign dack_o     = (active && attr_q.dma) || burst_run;
  assign done_o     = (ph_q == PH_DONE);

  // R5: never both strobes
  a_r5_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  // R3: address frozen across the active window
  a_r3_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && $past(active)) |-> $stable(bus_addr_o));

  // R11: zero setup puts the strobe right after acceptance
  a_r11_zero_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cfg_setup_i == '0) |=> (rd_o || wr_o));

  // R9: a running burst keeps the acknowledge up into the next cycle
  a_r9_dack_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_run && !done_o) |=> dack_o);

  // R7: ATA-mode DMA beats drive no card enable
  a_r7_dma_no_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ata_i && attr_q.dma) |-> !(ce1_o || ce2_o));

  // R4: done cycle leaves enables and strobes inactive
  a_r4_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(ce1_o || ce2_o || rd_o || wr_o || reg_o));

  // R1: no new request while an access runs
  a_r1_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active || done_o) |-> !req_ready_o);
endmodule

// File: tb/card_cycle_gen_tb.sv
module card_cycle_gen_tb;
  localparam int AW = 26;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic          req_write_i = 1'b0, req_word_i = 1'b0, req_dma_i = 1'b0;
  logic          req_reg_i = 1'b0, req_area_i = 1'b0, req_last_i = 1'b0;
  logic          burst_arm_i = 1'b0, cfg_ata_i = 1'b0;
  logic [3:0]    cfg_base_wait_i = '0;
  logic [1:0]    cfg_speed_i = '0;
  logic [3:0]    cfg_setup_i = '0, cfg_hold_i = '0;
  logic [2:0]    cfg_idle0_i = '0, cfg_idle1_i = '0;
  logic [AW-1:0] bus_addr_o;
  logic          ce1_o, ce2_o, reg_o, rd_o, wr_o, dack_o, done_o;

  int n_tests = 0, n_fail = 0;
  bit armed_m = 0, run_m = 0;

  always #4 clk_i = ~clk_i;

  card_cycle_gen u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i, .req_write_i,
    .req_word_i, .req_dma_i, .req_reg_i, .req_area_i, .req_last_i, .burst_arm_i,
    .cfg_ata_i, .cfg_base_wait_i, .cfg_speed_i, .cfg_setup_i, .cfg_hold_i,
    .cfg_idle0_i, .cfg_idle1_i, .bus_addr_o, .ce1_o, .ce2_o, .reg_o, .rd_o,
    .wr_o, .dack_o, .done_o
  );

  function automatic int adder_of(input logic [1:0] s);
    case (s)
      2'd0: return 0;
      2'd1: return 15;
      2'd2: return 30;
      default: return 50;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge of the done cycle
  task automatic run_txn(input logic [AW-1:0] a, input bit w, input bit wd,
                         input bit dma, input bit rg, input bit area,
                         input bit last, input bit arm, input bit b2b);
    int waits = 0, pre = 0, stb = 0, post = 0, guard = 0;
    int ce_err = 0, rw_err = 0, addr_err = 0, dack_err = 0;
    bit seen = 0, e1, e2, dk_done, ok_done;
    int exp_wait = b2b ? (area ? int'(cfg_idle1_i) : int'(cfg_idle0_i)) + 1 : 0;
    req_addr_i = a; req_write_i = w; req_word_i = wd; req_dma_i = dma;
    req_reg_i = rg; req_area_i = area; req_last_i = last;
    req_valid_i = 1'b1; burst_arm_i = arm;
    if (arm) armed_m = 1;
    #1;
    while (!req_ready_o && guard < 100) begin
      @(negedge clk_i);
      if (dack_o !== run_m) dack_err++;
      waits++; guard++;
    end
    check(waits == exp_wait, b2b ? "R10 idle gap" : "R1 ready", waits, exp_wait);
    if (dma && armed_m) run_m = 1;
    @(negedge clk_i);
    req_valid_i = 1'b0; burst_arm_i = 1'b0;
    if (cfg_ata_i) begin e1 = !dma && wd; e2 = !dma && !wd; end
    else begin e1 = 1'b1; e2 = wd; end
    guard = 0;
    while (!done_o && guard < 200) begin
      if (rd_o || wr_o) begin
        stb++; seen = 1;
        if (rd_o !== !w || wr_o !== w) rw_err++;
      end else if (seen) post++;
      else pre++;
      if (ce1_o !== e1 || ce2_o !== e2 || reg_o !== rg) ce_err++;
      if (bus_addr_o !== a) addr_err++;
      if (dack_o !== (dma | run_m)) dack_err++;
      @(negedge clk_i); guard++;
    end
    check(stb == int'(cfg_base_wait_i) + adder_of(cfg_speed_i) + 1, "R2 strobe len",
          stb, int'(cfg_base_wait_i) + adder_of(cfg_speed_i) + 1);
    check(pre == int'(cfg_setup_i), "R3 setup len", pre, int'(cfg_setup_i));
    check(post == int'(cfg_hold_i), "R4 hold len", post, int'(cfg_hold_i));
    check(addr_err == 0, "R3 addr/reg", addr_err, 0);
    check(rw_err == 0, "R5 strobe kind", rw_err, 0);
    check(ce_err == 0, cfg_ata_i ? "R7 ata enables" : "R6 enables", ce_err, 0);
    dk_done = run_m;
    ok_done = done_o && !ce1_o && !ce2_o && !rd_o && !wr_o && (dack_o === dk_done);
    check(ok_done, "R4 done cycle", ok_done, 1);
    check(dack_err == 0, armed_m ? "R9 burst dack" : "R8 dack", dack_err, 0);
    if (run_m && dma && last) begin run_m = 0; armed_m = 0; end
  endtask

  task automatic set_cfg(input bit ata, input int bw, input int sp, input int su,
                         input int ho, input int i0, input int i1);
    cfg_ata_i = ata; cfg_base_wait_i = 4'(bw); cfg_speed_i = 2'(sp);
    cfg_setup_i = 4'(su); cfg_hold_i = 4'(ho);
    cfg_idle0_i = 3'(i0); cfg_idle1_i = 3'(i1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(req_ready_o === 1'b1, "R1 reset ready", req_ready_o, 1);
    check({ce1_o, ce2_o, reg_o, rd_o, wr_o, dack_o, done_o} === 7'b0,
          "R1 reset outputs", {ce1_o, ce2_o, reg_o, rd_o, wr_o, dack_o, done_o}, 0);

    // R11 zero setup and hold, minimum strobe
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    run_txn(26'h0000123, 0, 0, 0, 0, 0, 0, 0, 0);
    // R2 largest timing, idle from area 1
    set_cfg(0, 15, 3, 15, 15, 2, 7);
    run_txn(26'h3FFFFFF, 1, 1, 0, 1, 1, 0, 0, 1);
    // R6 byte access in normal mode; R11 again back-to-back
    set_cfg(0, 3, 1, 0, 0, 5, 1);
    run_txn(26'h0ABCDEF, 0, 0, 0, 0, 0, 0, 0, 1);
    // R7 ATA CPU byte and word
    set_cfg(1, 2, 0, 1, 2, 0, 3);
    run_txn(26'h0000010, 0, 0, 0, 1, 0, 0, 0, 1);
    run_txn(26'h0000020, 1, 1, 0, 0, 1, 0, 0, 1);
    // R8 unarmed DMA, last flag ignored
    run_txn(26'h0000030, 0, 1, 1, 0, 0, 1, 0, 1);
    // R9 armed burst of three DMA beats, then two unarmed beats
    set_cfg(1, 1, 0, 2, 1, 1, 2);
    run_txn(26'h0000100, 0, 1, 1, 0, 0, 0, 1, 1);
    run_txn(26'h0000102, 0, 1, 1, 0, 1, 0, 0, 1);
    run_txn(26'h0000104, 0, 1, 1, 0, 0, 1, 0, 1);
    run_txn(26'h0000106, 1, 1, 1, 0, 0, 0, 0, 1);
    run_txn(26'h0000108, 1, 1, 1, 0, 1, 1, 0, 1);

    // random back-to-back traffic
    for (int i = 0; i < 60; i++) begin
      set_cfg(1'($urandom), int'($urandom_range(15)), int'($urandom_range(3)),
              int'($urandom_range(15)), int'($urandom_range(15)),
              int'($urandom_range(7)), int'($urandom_range(7)));
      run_txn(26'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom), 0, 1);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule